// File: doc/BRIEF.md
# Parking Address Bus Arbiter

This block arbitrates a shared address bus between one on-chip master and a parameterised number of external masters. The on-chip master receives its grant on a signal that stays inside the chip. Each external master has its own request input and its own grant output. When nothing is pending, the grant rests on the on-chip master. That master can then open an address tenure without first asking for the bus.

A bus-busy flag follows each address tenure. A transfer-start pulse sets the flag, and an address-acknowledge pulse clears it. The arbiter changes the grant only at certain points. It takes the grant away from the parked on-chip master as soon as any external request appears, even in the middle of a tenure. In the acknowledge cycle it re-examines all requests: the lowest-numbered requester wins, and if nothing is pending the grant returns to the park. An external master may withdraw its request after it has been granted and before it starts a tenure. While the bus is idle, the arbiter notices this and moves the grant on instead of waiting.

Grants are registered. Every decision made from the inputs of one cycle becomes visible on the grant outputs in the following cycle.

Top module: `addr_park_arb`

## Requirements
- R1: After reset, intGrant is 1, every bit of extGrant is 0 and busBusy is 0.
- R2: While intGrant is 1 and no extReq bit is set, intGrant stays 1 in the next cycle. This holds through tenures of the on-chip master (tsIn and aackIn pulses).
- R3: When intGrant is 1 and any extReq bit is set, the next cycle shows intGrant 0 and the winning external grant at 1. This holds even when tsIn is high in that same cycle.
- R4: busBusy is 1 in the cycle after tsIn is high. It is 0 in the cycle after aackIn is high with tsIn low. Otherwise it keeps its value.
- R5: In a cycle with aackIn high and at least one extReq bit set, the next cycle grants only the lowest-index requesting external master.
- R6: In a cycle with aackIn high and no extReq bit set, the next cycle shows intGrant 1 and extGrant all 0.
- R7: While busBusy is 1 and aackIn is low, an external grant does not change, whatever the request lines do.
- R8: While busBusy is 0, if the granted external master has its request low and tsIn is low, the grant moves in the next cycle. It goes to the lowest-index remaining requester, or to the park when there is none.
- R9: In every cycle exactly one of intGrant and the extGrant bits is 1.
- R10: When several external masters request together while the grant is parked, the lowest-index requester (bit 0 highest) wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| extReq | input | NUM_EXT | Bus requests from external masters, bit i for master i |
| tsIn | input | 1 | Transfer start of any master, opens an address tenure |
| aackIn | input | 1 | Address acknowledge, closes the current tenure |
| intGrant | output | 1 | Grant to the on-chip master, parking target |
| extGrant | output | NUM_EXT | One-hot grants to external masters |
| busBusy | output | 1 | High between transfer start and address acknowledge |

## Verification
Directed sequences cover several situations. Parked idle cycles and on-chip tenures with no requests show that the park is sticky. A request arriving together with transfer start shows that the grant can be taken away mid-tenure. Requests that change during a busy tenure separate holding the grant from re-arbitrating too early. Acknowledges with and without pending requests, and with several requests, separate the priority choice from the fallback to the park. A granted request that drops while the bus is idle exercises recovery without a tenure. A long random phase mixes all of these, and a behavioural model compares every output on every clock.

// File: rtl/apa_pkg.sv
package apa_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic rearb;   // load new winner (or park) into the grant register
  } strobe_t;

  // status from datapath back to control
  typedef struct packed {
    logic isInt;    // grant currently parked on the on-chip master
    logic ownerReq; // granted external master still requests
    logic anyReq;   // any external request pending
  } status_t;

endpackage

// File: rtl/apa_path.sv
module apa_path
  import apa_pkg::*;
#(
  parameter int NUM_EXT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extReq,
  input  strobe_t            stb,
  output status_t            sts,
  output logic               intGrant,
  output logic [NUM_EXT-1:0] extGrant
);

  localparam int GW = NUM_EXT + 1;

  logic [NUM_EXT-1:0] winner;
  logic [NUM_EXT:0]   blocked;
  logic [GW-1:0]      grantQ;
  logic [GW-1:0]      grantD;

  // fixed priority chain, bit 0 highest
  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < NUM_EXT; i++) begin : g_prio
    assign winner[i]    = extReq[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | extReq[i];
  end

  always_comb begin
    grantD = grantQ;
    if (stb.rearb) begin
      if (blocked[NUM_EXT]) grantD = {winner, 1'b0};
      else                  grantD = GW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) grantQ <= GW'(1);
    else       grantQ <= grantD;
  end

  assign sts.isInt    = grantQ[0];
  assign sts.anyReq   = blocked[NUM_EXT];
  assign sts.ownerReq = |(grantQ[GW-1:1] & extReq);

  assign intGrant = grantQ[0];
  assign extGrant = grantQ[GW-1:1];

endmodule

// File: rtl/apa_ctrl.sv
module apa_ctrl
  import apa_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tsIn,
  input  logic    aackIn,
  input  status_t sts,
  output strobe_t stb,
  output logic    busBusy
);

  logic busyQ;
  logic takeFromPark;
  logic recoverIdle;

  always_ff @(posedge clk) begin
    if (!rstN)       busyQ <= 1'b0;
    else if (tsIn)   busyQ <= 1'b1;
    else if (aackIn) busyQ <= 1'b0;
  end

  // parked grant yields to any external request, even mid-tenure
  assign takeFromPark = sts.isInt & sts.anyReq;
  // granted external master gave up its request before starting
  assign recoverIdle  = ~busyQ & ~sts.isInt & ~sts.ownerReq & ~tsIn;

  assign stb.rearb = aackIn | takeFromPark | recoverIdle;
  assign busBusy   = busyQ;

endmodule

// File: rtl/addr_park_arb.sv
module addr_park_arb
  import apa_pkg::*;
#(
  parameter int NUM_EXT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extReq,
  input  logic               tsIn,
  input  logic               aackIn,
  output logic               intGrant,
  output logic [NUM_EXT-1:0] extGrant,
  output logic               busBusy
);

  strobe_t stb;
  status_t sts;

  apa_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tsIn   (tsIn),
    .aackIn (aackIn),
    .sts    (sts),
    .stb    (stb),
    .busBusy(busBusy)
  );

  apa_path #(.NUM_EXT(NUM_EXT)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .extReq  (extReq),
    .stb     (stb),
    .sts     (sts),
    .intGrant(intGrant),
    .extGrant(extGrant)
  );

endmodule

// File: rtl/apa_checker.sv
module apa_checker #(
  parameter int NUM_EXT = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EXT-1:0] extReq,
  input logic               tsIn,
  input logic               aackIn,
  input logic               intGrant,
  input logic [NUM_EXT-1:0] extGrant,
  input logic               busBusy
);

  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({intGrant, extGrant}));

  a_r4_busy_set: assert property (@(posedge clk) disable iff (!rstN)
    tsIn |=> busBusy);

  a_r4_busy_clr: assert property (@(posedge clk) disable iff (!rstN)
    (aackIn && !tsIn) |=> !busBusy);

  a_r2_park_hold: assert property (@(posedge clk) disable iff (!rstN)
    (intGrant && extReq == '0) |=> intGrant);

  a_r3_leave_park: assert property (@(posedge clk) disable iff (!rstN)
    (intGrant && extReq != '0) |=> !intGrant);

  a_r6_ack_park: assert property (@(posedge clk) disable iff (!rstN)
    (aackIn && extReq == '0) |=> intGrant);

  a_r5_ack_prio: assert property (@(posedge clk) disable iff (!rstN)
    (aackIn && extReq != '0) |=>
      (extGrant == ($past(extReq) & (~$past(extReq) + 1'b1))));

  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && !aackIn && extGrant != '0) |=> $stable(extGrant));

  a_r8_withdraw: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && !tsIn && !aackIn && (extGrant & ~extReq) != '0) |=>
      !$stable(extGrant));

endmodule

bind addr_park_arb apa_checker #(.NUM_EXT(NUM_EXT)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .extReq  (extReq),
  .tsIn    (tsIn),
  .aackIn  (aackIn),
  .intGrant(intGrant),
  .extGrant(extGrant),
  .busBusy (busBusy)
);

// File: tb/sim_addr_park_arb.sv
module sim_addr_park_arb;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] extReq;
  logic         tsIn;
  logic         aackIn;
  logic         intGrant;
  logic [N-1:0] extGrant;
  logic         busBusy;

  int checks = 0;
  int errors = 0;

  // model state: owner -1 means parked on the on-chip master
  int mOwner;
  bit mBusy;

  always #2 clk = ~clk;

  addr_park_arb #(.NUM_EXT(N)) u0 (
    .clk(clk), .rstN(rstN), .extReq(extReq), .tsIn(tsIn), .aackIn(aackIn),
    .intGrant(intGrant), .extGrant(extGrant), .busBusy(busBusy)
  );

  function automatic int pickLowest(input logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return i;
    return -1;
  endfunction

  task automatic checkOne(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [N-1:0] expExt;
    expExt = '0;
    if (mOwner >= 0) expExt[mOwner] = 1'b1;
    checkOne({tag, " intGrant"}, 32'(intGrant), 32'(mOwner < 0));
    checkOne({tag, " extGrant"}, 32'(extGrant), 32'(expExt));
    checkOne({tag, " busBusy"},  32'(busBusy),  32'(mBusy));
    checkOne("R9 onehot", 32'($countones({intGrant, extGrant})), 32'd1);
  endtask

  // apply inputs for one cycle, advance the model, then compare after the edge
  task automatic step(input logic [N-1:0] r, input bit ts, input bit ack, input string tag);
    int w;
    extReq = r; tsIn = ts; aackIn = ack;
    w = pickLowest(r);
    if (mOwner < 0) begin
      if (w >= 0) mOwner = w;
    end else if (ack) begin
      mOwner = w;
    end else if (!mBusy && !ts && !r[mOwner]) begin
      mOwner = w;
    end
    mBusy = ts || (mBusy && !ack);
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; extReq = '0; tsIn = 1'b0; aackIn = 1'b0;
    mOwner = -1; mBusy = 1'b0;
    repeat (3) @(negedge clk);
    compareAll("R1 reset");
    rstN = 1'b1;

    // R2: sticky park, idle and through an on-chip tenure
    step(3'b000, 0, 0, "R2 idle");
    step(3'b000, 1, 0, "R2 ts");
    step(3'b000, 0, 0, "R2 busy");
    step(3'b000, 0, 1, "R2 ack");

    // R3: request together with on-chip transfer start
    step(3'b010, 1, 0, "R3 same-cycle");
    // R7: busy tenure, requests change, grant holds
    step(3'b001, 0, 0, "R7 hold");
    step(3'b100, 0, 0, "R7 hold2");
    // R5: ack with pending requests picks lowest index
    step(3'b101, 0, 1, "R5 ack prio");
    // R8: granted master withdraws while bus idle
    step(3'b100, 0, 0, "R8 withdraw to next");
    step(3'b000, 0, 0, "R8 withdraw to park");
    // R10: several requests while parked
    step(3'b110, 0, 0, "R10 prio");
    // R4/R6: external tenure then ack without requests
    step(3'b110, 1, 0, "R4 ext ts");
    step(3'b000, 0, 0, "R7 busy no req");
    step(3'b000, 0, 1, "R6 ack park");
    step(3'b000, 0, 0, "R4 cleared");

    // random mix
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] r;
      bit ts, ack;
      r = (($urandom % 4) == 0) ? N'($urandom) : extReq;
      ts  = !mBusy && (($urandom % 3) == 0);
      ack = mBusy && (($urandom % 3) == 0);
      step(r, ts, ack, "R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule